// File: doc/BRIEF.md
# Low-Power Entry and Wake Sequencer

This block moves a processor core between full operation and two low-power states. A one-cycle power-save command, qualified by a mode bit, sends the core either to idle, where only the CPU clock stops, or to sleep, where the CPU, peripheral and system clocks all stop. While the core is held, the block watches a set of wake events: interrupt requests with per-line enables and priorities, reset sources, and a watchdog timeout.

Leaving sleep is not immediate. The block first picks the clock source to restart. This is the live oscillator selection when clock switching is allowed, and the configured source otherwise. It then keeps the system clock gated until that source can be trusted. Every source waits out a short fixed delay, counted in clock cycles. Crystal-class sources must also see the oscillator startup timer report stable, and the PLL source must also see its lock flag. A low-power crystal that kept running through sleep is treated as an already-running source and waits only the short delay. After the hold-off, one release cycle turns the clocks back on before the run enable is raised. A reset source event from any state takes the full hold-off path using the configured source.

Top module: `lp_wake_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `cpu_clk_en`, `per_clk_en`, `sys_clk_en` and `run_en` are 1, and `wake_osc` equals `cfg_osc`.
- R2: In run, `save_cmd`=1 with `save_mode`=0 enters idle at the next edge: `cpu_clk_en`=0, `per_clk_en`=1, `sys_clk_en`=1, `run_en`=0.
- R3: In run, `save_cmd`=1 with `save_mode`=1 enters sleep at the next edge: all three clock enables and `run_en` are 0.
- R4: Interrupt line i is a wake event only when `irq_req[i]`, `irq_en[i]` and its priority field `irq_pri[i*PRI_W +: PRI_W]` is strictly greater than `cpu_ipl`. A request that is disabled or has a priority at or below the threshold leaves idle or sleep unchanged.
- R5: `wdt_to`=1 ends sleep. Any bit of `rst_src` high, in any state, enters the hold-off wait with `cfg_osc` as the restart source.
- R6: On a wake from sleep, the restart source is `cur_osc` when `clk_sw_en`=1, or `cfg_osc` otherwise. It appears on `wake_osc` from the edge that enters the hold-off wait.
- R7: Source codes 0 to 3 (fast RC, low-power RC, external clock, external RC) are short-delay sources. Code 5 (low-power crystal) is also a short-delay source when `lp_kept`=1 at the sleep wake. For a short-delay source, the outputs stay off for exactly `POR_CYC` cycles in the wait and then release.
- R8: Codes 4 and 7 (crystal), and code 5 when it is not kept running, leave the wait only once `POR_CYC` cycles have passed and `ost_done` is 1.
- R9: Code 6 (PLL) leaves the wait only once `POR_CYC` cycles have passed and `pll_lock` is 1.
- R10: Release lasts exactly one cycle, with all clock enables at 1 and `run_en`=0. `run_en` then rises.
- R11: In idle, an interrupt wake event or `wdt_to` goes to release at the next edge, with no hold-off.
- R12: `save_cmd` has no effect in any state other than run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_cmd | input | 1 | Power-save command pulse |
| save_mode | input | 1 | 1 = sleep, 0 = idle |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| irq_pri | input | N_IRQ*PRI_W | Packed per-line priorities |
| cpu_ipl | input | PRI_W | Current priority threshold |
| rst_src | input | N_RST | Reset source events |
| wdt_to | input | 1 | Watchdog timeout |
| pll_lock | input | 1 | PLL locked |
| ost_done | input | 1 | Oscillator startup timer expired |
| clk_sw_en | input | 1 | Clock switching allowed |
| cur_osc | input | 3 | Current oscillator selection |
| cfg_osc | input | 3 | Configured oscillator |
| lp_kept | input | 1 | Low-power crystal ran through sleep |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| sys_clk_en | output | 1 | System clock gate |
| run_en | output | 1 | Core run enable |
| wake_osc | output | 3 | Selected restart source |

## Verification
The bench targets the edges of interrupt qualification. A priority equal to the threshold, and a request with its enable off, must not wake the core; a comparator using >= or ignoring the enable would wake early. It counts the exact number of gated cycles for short-delay sources, which exposes an off-by-one in the delay counter. It holds `ost_done` and `pll_lock` low well past the delay to catch a design that releases on the timer alone. It also toggles `lp_kept` on the low-power crystal and `clk_sw_en`, so that a wrong path choice or a wrong source selection shows up as a different release cycle or a different `wake_osc`.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_WAIT    = 3'd3,
    ST_RELEASE = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    PATH_SHORT = 2'd0,
    PATH_OST   = 2'd1,
    PATH_PLL   = 2'd2
  } hold_path_t;

  localparam int OSC_W = 3;
  localparam logic [OSC_W-1:0] OSC_LPXT = 3'd5;
  localparam logic [OSC_W-1:0] OSC_PLL  = 3'd6;
endpackage

// File: rtl/lp_wake_detect.sv
module lp_wake_detect #(
  parameter int N_IRQ = 4,
  parameter int PRI_W = 3,
  parameter int N_RST = 3
) (
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ-1:0]       irq_en,
  input  logic [N_IRQ*PRI_W-1:0] irq_pri,
  input  logic [PRI_W-1:0]       cpu_ipl,
  input  logic                   wdt_to,
  input  logic [N_RST-1:0]       rst_src,
  output logic                   irq_wake,
  output logic                   rst_hit
);
  logic [N_IRQ-1:0] line_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign line_hit[i] = irq_req[i] & irq_en[i] &
                         (irq_pri[i*PRI_W +: PRI_W] > cpu_ipl);
  end

  assign irq_wake = (|line_hit) | wdt_to;
  assign rst_hit  = |rst_src;
endmodule

// File: rtl/lp_osc_class.sv
module lp_osc_class
  import lp_wake_pkg::*;
(
  input  logic [OSC_W-1:0] osc,
  input  logic             lp_kept,
  output hold_path_t       path
);
  always_comb begin
    if (osc == OSC_PLL)              path = PATH_PLL;
    else if (osc == OSC_LPXT)        path = lp_kept ? PATH_SHORT : PATH_OST;
    else if (osc[OSC_W-1])           path = PATH_OST;
    else                             path = PATH_SHORT;
  end
endmodule

// File: rtl/lp_por_timer.sv
module lp_por_timer #(
  parameter int POR_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = (POR_CYC < 2) ? 1 : $clog2(POR_CYC);
  localparam logic [CW-1:0] LOAD_VAL = CW'(POR_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lp_wake_seq.sv
module lp_wake_seq
  import lp_wake_pkg::*;
#(
  parameter int N_IRQ   = 4,
  parameter int PRI_W   = 3,
  parameter int N_RST   = 3,
  parameter int POR_CYC = 400
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   save_cmd,
  input  logic                   save_mode,
  input  logic [N_IRQ-1:0]       irq_req,
  input  logic [N_IRQ-1:0]       irq_en,
  input  logic [N_IRQ*PRI_W-1:0] irq_pri,
  input  logic [PRI_W-1:0]       cpu_ipl,
  input  logic [N_RST-1:0]       rst_src,
  input  logic                   wdt_to,
  input  logic                   pll_lock,
  input  logic                   ost_done,
  input  logic                   clk_sw_en,
  input  logic [2:0]             cur_osc,
  input  logic [2:0]             cfg_osc,
  input  logic                   lp_kept,
  output logic                   cpu_clk_en,
  output logic                   per_clk_en,
  output logic                   sys_clk_en,
  output logic                   run_en,
  output logic [2:0]             wake_osc
);
  seq_state_t       state_q, state_d;
  hold_path_t       path_q, path_d;
  logic [OSC_W-1:0] osc_d;
  logic             kept_d, tmr_load, tmr_done, irq_wake, rst_hit, stable_ok;

  lp_wake_detect #(.N_IRQ(N_IRQ), .PRI_W(PRI_W), .N_RST(N_RST)) u_det (
    .irq_req(irq_req), .irq_en(irq_en), .irq_pri(irq_pri), .cpu_ipl(cpu_ipl),
    .wdt_to(wdt_to), .rst_src(rst_src), .irq_wake(irq_wake), .rst_hit(rst_hit)
  );

  lp_osc_class u_cls (.osc(osc_d), .lp_kept(kept_d), .path(path_d));

  lp_por_timer #(.POR_CYC(POR_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .done(tmr_done)
  );

  always_comb begin
    unique case (path_q)
      PATH_OST: stable_ok = ost_done;
      PATH_PLL: stable_ok = pll_lock;
      default:  stable_ok = 1'b1;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    osc_d    = wake_osc;
    kept_d   = 1'b0;
    tmr_load = 1'b0;
    if (rst_hit) begin
      state_d  = ST_WAIT;
      osc_d    = cfg_osc;
      tmr_load = 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN:     if (save_cmd) state_d = save_mode ? ST_SLEEP : ST_IDLE;
        ST_IDLE:    if (irq_wake) state_d = ST_RELEASE;
        ST_SLEEP: begin
          if (irq_wake) begin
            state_d  = ST_WAIT;
            osc_d    = clk_sw_en ? cur_osc : cfg_osc;
            kept_d   = lp_kept;
            tmr_load = 1'b1;
          end
        end
        ST_WAIT:    if (tmr_done && stable_ok) state_d = ST_RELEASE;
        ST_RELEASE: state_d = ST_RUN;
        default:    state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      path_q     <= PATH_SHORT;
      wake_osc   <= cfg_osc;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      sys_clk_en <= 1'b1;
      run_en     <= 1'b1;
    end else begin
      state_q    <= state_d;
      wake_osc   <= osc_d;
      if (tmr_load) path_q <= path_d;
      cpu_clk_en <= (state_d == ST_RUN) || (state_d == ST_RELEASE);
      per_clk_en <= (state_d == ST_RUN) || (state_d == ST_RELEASE) || (state_d == ST_IDLE);
      sys_clk_en <= (state_d == ST_RUN) || (state_d == ST_RELEASE) || (state_d == ST_IDLE);
      run_en     <= (state_d == ST_RUN);
    end
  end
endmodule

// File: rtl/lp_wake_seq_chk.sv
module lp_wake_seq_chk
  import lp_wake_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input seq_state_t state_q,
  input hold_path_t path_q,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       sys_clk_en,
  input logic       run_en,
  input logic       irq_wake,
  input logic       rst_hit,
  input logic       tmr_done,
  input logic       pll_lock,
  input logic       ost_done
);
  assert_gates_off_R3: assert property (@(posedge clk) disable iff (rst)
    !per_clk_en |-> (!cpu_clk_en && !sys_clk_en && !run_en));

  assert_sleep_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !irq_wake && !rst_hit) |=> (state_q == ST_SLEEP));

  assert_short_release_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && path_q == PATH_SHORT && tmr_done && !rst_hit)
      |=> (state_q == ST_RELEASE));

  assert_ost_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && path_q == PATH_OST && !ost_done) |=> !cpu_clk_en);

  assert_pll_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && path_q == PATH_PLL && !pll_lock) |=> !cpu_clk_en);

  assert_run_after_release_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |-> $past(cpu_clk_en && !run_en));
endmodule

bind lp_wake_seq lp_wake_seq_chk u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .path_q(path_q),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .sys_clk_en(sys_clk_en),
  .run_en(run_en), .irq_wake(irq_wake), .rst_hit(rst_hit), .tmr_done(tmr_done),
  .pll_lock(pll_lock), .ost_done(ost_done)
);

// File: tb/sim_lp_wake_seq.sv
module sim_lp_wake_seq;
  localparam int N_IRQ = 4, PRI_W = 3, N_RST = 3, POR = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic save_cmd = 0, save_mode = 0, wdt_to = 0, pll_lock = 0, ost_done = 0;
  logic clk_sw_en = 0, lp_kept = 0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic [N_IRQ*PRI_W-1:0] irq_pri = '0;
  logic [PRI_W-1:0] cpu_ipl = '0;
  logic [N_RST-1:0] rst_src = '0;
  logic [2:0] cur_osc = 3'd0, cfg_osc = 3'd0, wake_osc;
  logic cpu_clk_en, per_clk_en, sys_clk_en, run_en;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  lp_wake_seq #(.N_IRQ(N_IRQ), .PRI_W(PRI_W), .N_RST(N_RST), .POR_CYC(POR)) u0 (
    .clk(clk), .rst(rst), .save_cmd(save_cmd), .save_mode(save_mode),
    .irq_req(irq_req), .irq_en(irq_en), .irq_pri(irq_pri), .cpu_ipl(cpu_ipl),
    .rst_src(rst_src), .wdt_to(wdt_to), .pll_lock(pll_lock), .ost_done(ost_done),
    .clk_sw_en(clk_sw_en), .cur_osc(cur_osc), .cfg_osc(cfg_osc), .lp_kept(lp_kept),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .sys_clk_en(sys_clk_en),
    .run_en(run_en), .wake_osc(wake_osc)
  );

  // Behavioural reference: 0 run, 1 idle, 2 sleep, 3 waiting, 4 release
  int m_st = 0, m_left = 0, m_osc = 0;
  string m_need = "none";

  function automatic bit any_irq();
    for (int i = 0; i < N_IRQ; i++)
      if (irq_req[i] && irq_en[i] && int'(irq_pri[i*PRI_W +: PRI_W]) > int'(cpu_ipl)) return 1;
    return 0;
  endfunction

  task automatic start_wait(input int o, input bit kept);
    m_st = 3; m_left = POR - 1; m_osc = o;
    if (o == 6) m_need = "pll";
    else if (o < 4 || (o == 5 && kept)) m_need = "none";
    else m_need = "ost";
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; m_osc = int'(cfg_osc); m_left = 0;
    end else if (rst_src != 0) begin
      start_wait(int'(cfg_osc), 0);
    end else begin
      if (m_st == 0) begin
        if (save_cmd) m_st = save_mode ? 2 : 1;
      end else if (m_st == 1) begin
        if (any_irq() || wdt_to) m_st = 4;
      end else if (m_st == 2) begin
        if (any_irq() || wdt_to) start_wait(clk_sw_en ? int'(cur_osc) : int'(cfg_osc), lp_kept);
      end else if (m_st == 3) begin
        if (m_left == 0 && (m_need == "none" || (m_need == "ost" && ost_done) ||
                            (m_need == "pll" && pll_lock))) m_st = 4;
        else if (m_left > 0) m_left--;
      end else begin
        m_st = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int e_cpu, e_per, e_run;
      e_cpu = (m_st == 0 || m_st == 4) ? 1 : 0;
      e_per = (m_st == 0 || m_st == 4 || m_st == 1) ? 1 : 0;
      e_run = (m_st == 0) ? 1 : 0;
      chk(cpu_clk_en == e_cpu, "R2 cpu_clk_en model", cpu_clk_en, e_cpu);
      chk(per_clk_en == e_per && sys_clk_en == e_per, "R3 per/sys gates model",
          {per_clk_en, sys_clk_en}, {e_per[0], e_per[0]});
      chk(run_en == e_run, "R10 run_en model", run_en, e_run);
      chk(int'(wake_osc) == m_osc, "R6 wake_osc model", wake_osc, m_osc);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_save(input bit mode);
    save_cmd = 1; save_mode = mode; step(1); save_cmd = 0;
  endtask

  // Counts negedges until cpu_clk_en returns (release)
  task automatic count_to_release(output int k);
    k = 0;
    do begin step(1); k++; end while (!cpu_clk_en && k < 200);
  endtask

  int k;

  initial begin
    irq_pri = {3'd1, 3'd3, 3'd5, 3'd2};  // line3=1, line2=3, line1=5, line0=2
    cpu_ipl = 3'd3; cfg_osc = 3'd2;
    step(3);
    chk(cpu_clk_en && per_clk_en && sys_clk_en && run_en, "R1 gates in reset",
        {cpu_clk_en, per_clk_en, sys_clk_en, run_en}, 15);
    rst = 0; step(1);
    chk(run_en && cpu_clk_en && wake_osc == 3'd2, "R1 after reset", wake_osc, 2);

    // Idle entry, non-qualifying requests, then wake
    pulse_save(0);
    chk(!cpu_clk_en && per_clk_en && sys_clk_en && !run_en, "R2 idle gates",
        {cpu_clk_en, per_clk_en, sys_clk_en, run_en}, 6);
    irq_req = 4'b0100; irq_en = 4'b0100; step(3);  // priority 3 == threshold
    chk(!run_en && !cpu_clk_en, "R4 equal priority ignored in idle", cpu_clk_en, 0);
    irq_req = 4'b0010; irq_en = 4'b0000; step(3);  // high priority but disabled
    chk(!cpu_clk_en, "R4 disabled line ignored", cpu_clk_en, 0);
    irq_en = 4'b0010; step(1);
    chk(cpu_clk_en && !run_en, "R11 idle wake goes straight to release", run_en, 0);
    step(1);
    chk(run_en, "R10 run after release", run_en, 1);
    irq_req = '0; irq_en = '0;

    // Sleep with fast RC, command ignored while asleep
    clk_sw_en = 1; cur_osc = 3'd0;
    pulse_save(1);
    chk(!cpu_clk_en && !per_clk_en && !sys_clk_en && !run_en, "R3 sleep gates",
        {cpu_clk_en, per_clk_en, sys_clk_en, run_en}, 0);
    save_cmd = 1; save_mode = 0; step(3); save_cmd = 0;
    chk(!per_clk_en, "R12 save_cmd ignored in sleep", per_clk_en, 0);
    irq_req = 4'b0001; irq_en = 4'b0001; cpu_ipl = 3'd2; step(3);
    chk(!per_clk_en, "R4 priority at threshold does not wake sleep", per_clk_en, 0);
    cpu_ipl = 3'd1;
    count_to_release(k);
    chk(k == POR + 1, "R7 short delay length", k, POR + 1);
    chk(wake_osc == 3'd0, "R6 current selection used", wake_osc, 0);
    irq_req = '0; irq_en = '0; step(2);

    // PLL wake by watchdog
    cur_osc = 3'd6; pll_lock = 0;
    pulse_save(1);
    wdt_to = 1; step(1); wdt_to = 0;
    step(3 * POR);
    chk(!sys_clk_en, "R9 held until PLL lock", sys_clk_en, 0);
    chk(wake_osc == 3'd6, "R5 watchdog woke with PLL source", wake_osc, 6);
    pll_lock = 1; step(1);
    chk(cpu_clk_en && !run_en, "R9 release after lock", cpu_clk_en, 1);
    step(2); pll_lock = 0;

    // Switching disabled, crystal config, startup timer gating
    clk_sw_en = 0; cfg_osc = 3'd4; ost_done = 0;
    pulse_save(1);
    irq_req = 4'b0010; irq_en = 4'b0010; step(1); irq_req = '0;
    step(2 * POR);
    chk(!sys_clk_en, "R8 held until oscillator stable", sys_clk_en, 0);
    chk(wake_osc == 3'd4, "R6 configured source used", wake_osc, 4);
    ost_done = 1; step(1);
    chk(cpu_clk_en, "R8 release after stable", cpu_clk_en, 1);
    step(2); ost_done = 0;

    // Low-power crystal kept running: short path; not kept: startup path
    clk_sw_en = 1; cur_osc = 3'd5; lp_kept = 1;
    pulse_save(1);
    irq_req = 4'b0010; step(1); irq_req = '0;
    k = 1;
    while (!cpu_clk_en && k < 200) begin step(1); k++; end
    chk(k == POR + 1, "R7 kept low-power crystal short delay", k, POR + 1);
    step(2); lp_kept = 0;
    pulse_save(1);
    irq_req = 4'b0010; step(1); irq_req = '0;
    step(2 * POR);
    chk(!cpu_clk_en, "R8 low-power crystal not kept waits", cpu_clk_en, 0);
    ost_done = 1; step(2); ost_done = 0; step(1);

    // Reset source from run uses configured source
    cfg_osc = 3'd1; rst_src = 3'b010; step(1); rst_src = '0;
    chk(!run_en && wake_osc == 3'd1, "R5 reset source enters wait", wake_osc, 1);
    count_to_release(k);
    chk(k == POR, "R5 reset path delay", k, POR);
    step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule